// File: doc/BRIEF.md
# Streaming Least-Squares Phase Estimator

This block estimates the phase of a periodic intensity profile, as a fringe pattern or a scanned grating line gives it. A profile is `NS` pixels that arrive on consecutive clock cycles, flagged by a start marker on the first pixel. The block scales each pixel up by a power of two. While the pixels stream in, it accumulates four running sums: plain, index-weighted, cosine-weighted and sine-weighted. The cosine and sine weights come from an eight-entry table whose entries are integers scaled by 1024.

From these sums the block finds the least-squares slope of the profile and removes that slope from the two correlation sums. The arithmetic uses only constant terms, integer products and shifts. Division by the fixed variance denominator is a multiplication by a precomputed reciprocal followed by a right shift. A shift-and-add arctangent turns the corrected cosine and sine sums into a signed 16-bit angle.

The datapath takes a new profile every `INTERVAL` cycles. Each result appears exactly `LATENCY` cycles after the first pixel of its profile, so a host can place its results by counting cycles.

Top module: `phase_est`

## Requirements
- R1: While reset is asserted and after it is released, `phase_valid` is 0 and `phase` is 0 until the first result arrives.
- R2: A profile starts on a cycle with `pix_valid`=1 and `pix_sop`=1 that is accepted. Beat k (k = 0..NS-1) is the k-th cycle counted from that start. A beat with `pix_valid`=0 contributes a pixel value of zero.
- R3: A start marker that comes fewer than `INTERVAL` cycles after the last accepted start is ignored. This includes a marker that falls inside a running profile. The pixels that follow an ignored marker produce no result.
- R4: Each pixel is scaled as x = pix << PS. The sums are S0 = Σx, S1 = Σk·x, SC = Σx·COS[k mod 8] and SS = Σx·SIN[k mod 8]. COS over index 0..7 is 1024, 724, 0, -724, -1024, -724, 0, 724, and SIN is 0, 724, 1024, 724, 0, -724, -1024, -724.
- R5: The slope is computed as N2 = 2·S1 - (NS-1)·S0 and slope = (N2·RCP) >>> RSH. Here RCP = floor(2^(RSH+BF) / (2·D)) and D = NS·(NS²-1)/12.
- R6: The detrended sums are CD = SC - ((slope·TC) >>> BF) and SD = SS - ((slope·TS) >>> BF), where TC = Σk·COS[k mod 8] and TS = Σk·SIN[k mod 8] over one profile.
- R7: The arctangent stage first pre-rotates the vector. If CD < 0 and SD ≥ 0, the vector becomes (SD, -CD) with starting angle +16384. If CD < 0 and SD < 0, it becomes (-SD, CD) with starting angle -16384. Otherwise it stays (CD, SD) with starting angle 0. Then 14 steps i = 0..13 follow. When y ≥ 0 a step does x += y>>>i, y -= x>>>i and angle += A[i]; otherwise it applies the opposite signs. A = 8192, 4836, 2555, 1297, 651, 326, 163, 81, 41, 20, 10, 5, 3, 1. `phase` is the angle modulo 2^16, where 32768 stands for pi.
- R8: `phase_valid` goes high right after the clock edge that comes `LATENCY` edges after the edge that captured beat 0.
- R9: Profiles started exactly `INTERVAL` cycles apart are all accepted. They produce one result each, in order, with no interference between them.
- R10: `phase_valid` is a one-cycle pulse. `phase` changes only in a cycle where `phase_valid` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid | input | 1 | Pixel beat qualifier |
| pix_sop | input | 1 | Marks beat 0 of a profile |
| pix_data | input | PIX_W | Unsigned pixel intensity |
| phase_valid | output | 1 | One-cycle result strobe |
| phase | output | 16 | Signed phase, 32768 = pi |

## Verification
The hardest cases to reach from the ports are start markers that arrive while the block is still busy. This covers a marker inside a running profile, a marker right after one profile ends but before the interval has elapsed, and a marker exactly one interval later. The stimulus sends profiles with no idle gap, so the following marker lands 25 cycles after the previous start. It also sends profiles exactly 40 cycles apart to cover the acceptance boundary. Every result is matched to its own profile by value and by arrival cycle. All four pre-rotation quadrants of the arctangent are reached by sweeping the phase shift of synthetic sinusoids through all eight table positions with added ramps. Pixels with `pix_valid` low are mixed into random profiles to exercise the zero-fill rule.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int WD   = 64;   // internal arithmetic width
  localparam int PH_W = 16;   // output angle width, 2^(PH_W-1) = pi
  localparam int ITER = 14;   // arctangent steps

  typedef logic signed [WD-1:0] wide_t;

  // cosine table, eight points per period, scaled by 1024
  function automatic wide_t cos_lut(input logic [2:0] k);
    case (k)
      3'd0:    cos_lut = 64'sd1024;
      3'd1:    cos_lut = 64'sd724;
      3'd2:    cos_lut = 64'sd0;
      3'd3:    cos_lut = -64'sd724;
      3'd4:    cos_lut = -64'sd1024;
      3'd5:    cos_lut = -64'sd724;
      3'd6:    cos_lut = 64'sd0;
      default: cos_lut = 64'sd724;
    endcase
  endfunction

  // sine is the cosine delayed by a quarter period
  function automatic wide_t sin_lut(input logic [2:0] k);
    sin_lut = cos_lut(k - 3'd2);
  endfunction

  // atan(2^-i) in units where 32768 = pi
  function automatic logic [PH_W-1:0] atan_lut(input logic [3:0] i);
    case (i)
      4'd0:    atan_lut = 16'd8192;
      4'd1:    atan_lut = 16'd4836;
      4'd2:    atan_lut = 16'd2555;
      4'd3:    atan_lut = 16'd1297;
      4'd4:    atan_lut = 16'd651;
      4'd5:    atan_lut = 16'd326;
      4'd6:    atan_lut = 16'd163;
      4'd7:    atan_lut = 16'd81;
      4'd8:    atan_lut = 16'd41;
      4'd9:    atan_lut = 16'd20;
      4'd10:   atan_lut = 16'd10;
      4'd11:   atan_lut = 16'd5;
      4'd12:   atan_lut = 16'd3;
      4'd13:   atan_lut = 16'd1;
      default: atan_lut = 16'd0;
    endcase
  endfunction

  // sum of k * table[k mod 8] over one profile of n samples
  function automatic wide_t ramp_dot(input int n, input bit sine);
    wide_t acc;
    acc = '0;
    for (int k = 0; k < n; k++)
      acc += wide_t'(k) * (sine ? sin_lut(3'(k)) : cos_lut(3'(k)));
    return acc;
  endfunction
endpackage

// File: rtl/phs_accum.sv
module phs_accum
  import phs_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int NS       = 24,
  parameter int INTERVAL = 40,
  parameter int PS       = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [PIX_W-1:0] in_pix,
  output logic             start_o,
  output logic             done_o,
  output wide_t            s0_o,
  output wide_t            s1_o,
  output wide_t            sc_o,
  output wide_t            ss_o
);
  localparam int IW = $clog2(NS);
  localparam int GW = $clog2(INTERVAL);

  logic          active_q, active_n, done_q, done_n;
  logic [IW-1:0] idx_q, idx_n, beat;
  logic [GW-1:0] gap_q, gap_n;
  logic          gap_ok, start, take, last;
  wide_t         xs, s0_q, s1_q, sc_q, ss_q, s0_n, s1_n, sc_n, ss_n;

  always_comb begin
    gap_ok   = (gap_q == GW'(INTERVAL-1));
    start    = in_valid && in_sop && gap_ok;
    take     = start || active_q;
    beat     = start ? '0 : idx_q;
    last     = take && (beat == IW'(NS-1));
    xs       = in_valid ? ($signed({{(WD-PIX_W){1'b0}}, in_pix}) <<< PS) : '0;
    active_n = take && !last;
    done_n   = last;
    idx_n    = beat + IW'(1);
    gap_n    = start ? '0 : (gap_ok ? gap_q : gap_q + GW'(1));
    s0_n     = (start ? '0 : s0_q) + xs;
    s1_n     = (start ? '0 : s1_q) + xs * wide_t'(beat);
    sc_n     = (start ? '0 : sc_q) + xs * cos_lut(beat[2:0]);
    ss_n     = (start ? '0 : ss_q) + xs * sin_lut(beat[2:0]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      gap_q    <= GW'(INTERVAL-1);
      idx_q    <= '0;
      s0_q     <= '0;
      s1_q     <= '0;
      sc_q     <= '0;
      ss_q     <= '0;
    end else begin
      active_q <= active_n;
      done_q   <= done_n;
      gap_q    <= gap_n;
      if (take) begin
        idx_q <= idx_n;
        s0_q  <= s0_n;
        s1_q  <= s1_n;
        sc_q  <= sc_n;
        ss_q  <= ss_n;
      end
    end
  end

  assign start_o = start;
  assign done_o  = done_q;
  assign s0_o    = s0_q;
  assign s1_o    = s1_q;
  assign sc_o    = sc_q;
  assign ss_o    = ss_q;

  // R2: end of a profile is a single-cycle event
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R3: a running profile is never restarted by a marker
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q |-> !start);
endmodule

// File: rtl/phs_detrend.sv
module phs_detrend
  import phs_pkg::*;
#(
  parameter int NS  = 24,
  parameter int RSH = 24,
  parameter int BF  = 8
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  go_i,
  input  wide_t s0_i,
  input  wide_t s1_i,
  input  wide_t sc_i,
  input  wide_t ss_i,
  output logic  ok_o,
  output wide_t cd_o,
  output wide_t sd_o
);
  localparam int     D   = NS * (NS * NS - 1) / 12;
  localparam longint RCP = (longint'(1) <<< (RSH + BF)) / longint'(2 * D);
  localparam wide_t  TC  = ramp_dot(NS, 1'b0);
  localparam wide_t  TS  = ramp_dot(NS, 1'b1);

  logic [3:0] v_q;
  wide_t num_q, c_q, s_q, slope_q, pc_q, ps_q, cd_q, sd_q;
  wide_t num_n, slope_n, pc_n, ps_n, cd_n, sd_n;

  always_comb begin
    num_n   = (s1_i <<< 1) - s0_i * wide_t'(NS - 1);
    slope_n = (num_q * wide_t'(RCP)) >>> RSH;
    pc_n    = slope_q * TC;
    ps_n    = slope_q * TS;
    cd_n    = c_q - (pc_q >>> BF);
    sd_n    = s_q - (ps_q >>> BF);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= '0;
      num_q   <= '0;
      c_q     <= '0;
      s_q     <= '0;
      slope_q <= '0;
      pc_q    <= '0;
      ps_q    <= '0;
      cd_q    <= '0;
      sd_q    <= '0;
    end else begin
      v_q <= {v_q[2:0], go_i};
      if (go_i) begin
        num_q <= num_n;
        c_q   <= sc_i;
        s_q   <= ss_i;
      end
      if (v_q[0]) slope_q <= slope_n;
      if (v_q[1]) begin
        pc_q <= pc_n;
        ps_q <= ps_n;
      end
      if (v_q[2]) begin
        cd_q <= cd_n;
        sd_q <= sd_n;
      end
    end
  end

  assign ok_o = v_q[3];
  assign cd_o = cd_q;
  assign sd_o = sd_q;

  // R9: a new profile never enters while the previous one is in flight
  a_r9_detrend_free: assert property (@(posedge clk) disable iff (!rst_ni)
    go_i |-> (v_q == 4'd0));
endmodule

// File: rtl/phs_cordic.sv
module phs_cordic
  import phs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            go_i,
  input  wide_t           cd_i,
  input  wide_t           sd_i,
  output logic            done_o,
  output logic [PH_W-1:0] ang_o
);
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic [3:0]      it_q, it_n;
  logic            busy_q, busy_n, done_q, done_n, last;
  wide_t           x_q, y_q, x_n, y_n, xs, ys;
  logic [PH_W-1:0] z_q, z_n;

  always_comb begin
    xs     = x_q >>> it_q;
    ys     = y_q >>> it_q;
    last   = busy_q && (it_q == 4'(ITER - 1));
    x_n    = x_q;
    y_n    = y_q;
    z_n    = z_q;
    it_n   = it_q;
    busy_n = busy_q && !last;
    done_n = last;
    if (go_i) begin
      it_n   = '0;
      busy_n = 1'b1;
      if (!cd_i[WD-1]) begin
        x_n = cd_i;  y_n = sd_i;  z_n = '0;
      end else if (!sd_i[WD-1]) begin
        x_n = sd_i;  y_n = -cd_i; z_n = QUARTER;
      end else begin
        x_n = -sd_i; y_n = cd_i;  z_n = -QUARTER;
      end
    end else if (busy_q) begin
      it_n = it_q + 4'd1;
      if (!y_q[WD-1]) begin
        x_n = x_q + ys;  y_n = y_q - xs;  z_n = z_q + atan_lut(it_q);
      end else begin
        x_n = x_q - ys;  y_n = y_q + xs;  z_n = z_q - atan_lut(it_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
    end else begin
      it_q   <= it_n;
      busy_q <= busy_n;
      done_q <= done_n;
      x_q    <= x_n;
      y_q    <= y_n;
      z_q    <= z_n;
    end
  end

  assign done_o = done_q;
  assign ang_o  = z_q;

  // R7: after pre-rotation the vector stays in the right half-plane
  a_r7_x_nonneg: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> !x_q[WD-1]);
  // R9: the angle unit is idle whenever new sums arrive
  a_r9_cordic_free: assert property (@(posedge clk) disable iff (!rst_ni)
    go_i |-> !busy_q);
endmodule

// File: rtl/phase_est.sv
module phase_est
  import phs_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int NS       = 24,
  parameter int INTERVAL = 40,
  parameter int LATENCY  = 112,
  parameter int PS       = 4,
  parameter int RSH      = 24,
  parameter int BF       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sop,
  input  logic [PIX_W-1:0] pix_data,
  output logic             phase_valid,
  output logic [PH_W-1:0]  phase
);
  localparam int RAW  = NS + 4 + ITER;
  localparam int PAD  = LATENCY - RAW;
  localparam int PADC = (PAD < 1) ? 1 : PAD;
  localparam int PW   = $clog2(LATENCY / INTERVAL + 3);

  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic            acc_start, acc_done, dt_ok, c_done;
  wide_t           s0, s1, sc, ss, cd, sd;
  logic [PH_W-1:0] c_ang;

  phs_accum #(.PIX_W(PIX_W), .NS(NS), .INTERVAL(INTERVAL), .PS(PS)) u_acc (
    .clk(clk), .rst_ni(rst_i), .in_valid(pix_valid), .in_sop(pix_sop),
    .in_pix(pix_data), .start_o(acc_start), .done_o(acc_done),
    .s0_o(s0), .s1_o(s1), .sc_o(sc), .ss_o(ss));

  phs_detrend #(.NS(NS), .RSH(RSH), .BF(BF)) u_dt (
    .clk(clk), .rst_ni(rst_i), .go_i(acc_done), .s0_i(s0), .s1_i(s1),
    .sc_i(sc), .ss_i(ss), .ok_o(dt_ok), .cd_o(cd), .sd_o(sd));

  phs_cordic u_cor (
    .clk(clk), .rst_ni(rst_i), .go_i(dt_ok), .cd_i(cd), .sd_i(sd),
    .done_o(c_done), .ang_o(c_ang));

  // alignment stages: stretch the raw pipeline to the fixed latency
  logic            dv_q [PADC];
  logic [PH_W-1:0] dp_q [PADC];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int k = 0; k < PADC; k++) begin
        dv_q[k] <= 1'b0;
        dp_q[k] <= '0;
      end
    end else begin
      dv_q[0] <= c_done;
      if (c_done) dp_q[0] <= c_ang;
      for (int k = 1; k < PADC; k++) begin
        dv_q[k] <= dv_q[k-1];
        if (dv_q[k-1]) dp_q[k] <= dp_q[k-1];
      end
    end
  end

  assign phase_valid = dv_q[PADC-1];
  assign phase       = dp_q[PADC-1];

  // checker state: profiles accepted but not yet delivered
  logic [PW-1:0] pend_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) pend_q <= '0;
    else if (acc_start && !phase_valid) pend_q <= pend_q + PW'(1);
    else if (!acc_start && phase_valid) pend_q <= pend_q - PW'(1);
  end

  // R8: no result without an accepted profile behind it
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_i)
    phase_valid |-> (pend_q != '0));
  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    phase_valid |=> !phase_valid);
  // R10: the angle only moves together with the strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(phase) |-> phase_valid);
endmodule

// File: tb/tb_phase_est.sv
module tb_phase_est;
  localparam int PIX_W = 12, NS = 24, INTERVAL = 40, LAT = 112;
  localparam int PS = 4, RSH = 24, BF = 8;

  logic clk = 1'b0, rst_n = 1'b0, pix_valid = 1'b0, pix_sop = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic phase_valid;
  logic [15:0] phase;

  always #10 clk = ~clk;

  phase_est dut (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sop(pix_sop),
                 .pix_data(pix_data), .phase_valid(phase_valid), .phase(phase));

  int n_chk = 0, n_bad = 0, cyc = 0, last_acc = -1000, stab_bad = 0;
  int pbuf [NS];
  bit vmask [NS];
  logic [15:0] exp_ph [$];
  int exp_t [$];
  string exp_tag [$];
  logic [15:0] last_phase = '0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint tcos(input int k);
    case (k % 8)
      0: return 1024;  1: return 724;   2: return 0;     3: return -724;
      4: return -1024; 5: return -724;  6: return 0;     default: return 724;
    endcase
  endfunction
  function automatic longint tsin(input int k);
    case (k % 8)
      0: return 0;     1: return 724;   2: return 1024;  3: return 724;
      4: return 0;     5: return -724;  6: return -1024; default: return -724;
    endcase
  endfunction

  function automatic logic [15:0] model();
    int atn [14] = '{8192, 4836, 2555, 1297, 651, 326, 163, 81, 41, 20, 10, 5, 3, 1};
    longint s0 = 0, s1 = 0, sc = 0, ss = 0, x, num, rcp, slope, tc = 0, ts = 0;
    longint cd, sd, cx, cy, nx, ny;
    logic [15:0] z;
    longint d = NS * (NS * NS - 1) / 12;
    for (int k = 0; k < NS; k++) begin
      x  = vmask[k] ? (longint'(pbuf[k]) <<< PS) : 0;
      s0 += x; s1 += x * k; sc += x * tcos(k); ss += x * tsin(k);
      tc += k * tcos(k); ts += k * tsin(k);
    end
    num   = 2 * s1 - (NS - 1) * s0;
    rcp   = (longint'(1) <<< (RSH + BF)) / (2 * d);
    slope = (num * rcp) >>> RSH;
    cd    = sc - ((slope * tc) >>> BF);
    sd    = ss - ((slope * ts) >>> BF);
    if (cd >= 0)      begin cx = cd;  cy = sd;  z = 16'd0;     end
    else if (sd >= 0) begin cx = sd;  cy = -cd; z = 16'd16384; end
    else              begin cx = -sd; cy = cd;  z = -16'd16384; end
    for (int i = 0; i < 14; i++) begin
      if (cy >= 0) begin nx = cx + (cy >>> i); ny = cy - (cx >>> i); z = z + 16'(atn[i]); end
      else         begin nx = cx - (cy >>> i); ny = cy + (cx >>> i); z = z - 16'(atn[i]); end
      cx = nx; cy = ny;
    end
    return z;
  endfunction

  // drive pbuf/vmask as one profile, then one idle beat
  task automatic send(input string tag);
    bit acc;
    @(negedge clk);
    acc = (cyc - last_acc) >= INTERVAL;
    if (acc) begin
      last_acc = cyc;
      exp_ph.push_back(model());
      exp_t.push_back(cyc + 1 + LAT);
      exp_tag.push_back(tag);
    end
    for (int k = 0; k < NS; k++) begin
      if (k > 0) @(negedge clk);
      pix_sop = (k == 0); pix_valid = vmask[k]; pix_data = PIX_W'(pbuf[k]);
    end
    @(negedge clk);
    pix_sop = 1'b0; pix_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int clampp(input int v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : v);
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (phase_valid) begin
        if (exp_ph.size() == 0) chk(1'b0, "R3 unexpected result", phase, -1);
        else begin
          chk(phase == exp_ph[0], {"R7 phase ", exp_tag[0]}, phase, exp_ph[0]);
          chk(cyc == exp_t[0], {"R8 latency ", exp_tag[0]}, cyc, exp_t[0]);
          void'(exp_ph.pop_front()); void'(exp_t.pop_front()); void'(exp_tag.pop_front());
        end
      end else if (phase !== last_phase) stab_bad++;
      last_phase = phase;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(phase_valid == 1'b0, "R1 valid in reset", phase_valid, 0);
    chk(phase == 16'd0, "R1 phase in reset", phase, 0);
    rst_n = 1'b1;
    idle(4);
    chk(phase_valid == 1'b0, "R1 valid after reset", phase_valid, 0);
    chk(phase == 16'd0, "R1 phase after reset", phase, 0);
    mon_on = 1'b1;

    // R4 R9: sinusoid sweep over all table shifts, amplitudes, ramps, 40 apart
    for (int sh = 0; sh < 8; sh++)
      for (int a = 0; a < 2; a++)
        for (int r = 0; r < 3; r++) begin
          for (int k = 0; k < NS; k++) begin
            pbuf[k] = clampp(2000 + int'(((a ? 1500 : 300) * tcos(k + sh)) / 1024)
                             + (r == 0 ? 0 : (r == 1 ? 17 : -23)) * k);
            vmask[k] = 1'b1;
          end
          send("R4 sinus");
          idle(INTERVAL - NS - 1);
        end

    // R5 R6: pure ramps, slope must be removed
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < NS; k++) begin pbuf[k] = 100 + 40 * r * k; vmask[k] = 1'b1; end
      send("R5 ramp");
      idle(INTERVAL - NS - 1);
    end

    // R6: extremes
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < NS; k++) begin
        pbuf[k] = (t == 0) ? 4095 : ((t == 1) ? 0 : ((k % 2) ? 4095 : 0));
        vmask[k] = 1'b1;
      end
      send("R6 extreme");
      idle(INTERVAL - NS - 1);
    end

    // R2: random pixels with invalid beats filled as zero
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < NS; k++) begin
        pbuf[k] = int'($urandom % 4096);
        vmask[k] = (t < 2) ? 1'b1 : ($urandom % 4 != 0);
      end
      vmask[0] = 1'b1;
      send("R2 gaps");
      idle(INTERVAL - NS - 1);
    end

    // R3: marker 25 cycles after a start is dropped, the next at 50 is taken
    for (int k = 0; k < NS; k++) begin pbuf[k] = 1000 + 30 * k; vmask[k] = 1'b1; end
    send("R3 first");
    for (int k = 0; k < NS; k++) pbuf[k] = 3000 - 50 * k;
    send("R3 dropped");
    for (int k = 0; k < NS; k++) pbuf[k] = 2000 + int'((900 * tsin(k + 3)) / 1024);
    send("R3 after");
    idle(LAT + 60);

    chk(exp_ph.size() == 0, "R9 all results delivered", exp_ph.size(), 0);
    chk(stab_bad == 0, "R10 phase held between strobes", stab_bad, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule